// File: doc/BRIEF.md
# Qualified Event/Duration Performance Counter

This block is a hardware performance counter driven by a programmable qualifier. Six qualifier terms are combined with a logical AND. They look at internal channel activity, the microcode state, an external probe line, cache activity, the active interrupt level and the user/exec mode. Each term has per-source enable bits. All terms except the interrupt-level term also have a don't-care bit that forces the term true.

The counter runs in one of two modes. In duration mode it advances at half the clock rate for as long as the qualified condition holds. In event mode it advances once for each false-to-true transition of the condition.

Software sets up the block with a single control word. It writes the qualifier enables, the mode and an optional clear in one cycle. It reads the count as one registered value that wraps silently at its width.

Top module: `perf_qual_counter`

## Requirements
- R1: After reset the count is 0 and every control field is 0. With that control word the condition is false, so the count stays 0 whatever the status inputs are. `cfgData` has no effect unless `cfgWrite` is high.
- R2: Control word layout with NCH=8 and NLVL=8. Channel enables are bits [7:0], channel don't-care is bit 8, state don't-care is bit 9, probe-low enable is bit 10 and probe don't-care is bit 11. Cache enables are bits [15:12]. Cache don't-care is bit 16. Level enables are bits [24:17]. The no-level enable is bit 25, the user enable is bit 26, the mode don't-care is bit 27 and event mode is bit 28. Clear is bit 29 and is not stored. The word is loaded on a clock edge where `cfgWrite` is high.
- R3: The channel term is true when some `chanBusy[i]` is set together with channel enable i, or when channel don't-care is set.
- R4: The state term is true when `ucodeState` equals 2'b01, or when state don't-care is set.
- R5: The probe term is true when `probeIn` differs from the probe-low enable bit, or when probe don't-care is set.
- R6: The cache term is true when some `cacheAct[k]` is set together with cache enable k, or when cache don't-care is set. The index k is 0 for fill read, 1 for waiting on cache, 2 for processor writeback and 3 for sweep writeback.
- R7: The level term looks at the lowest set index in `lvlHeld`, which is the highest priority level. The term is true when that level's enable is set. When no level is held, the term is true if the no-level enable is set. Lower levels that are held are ignored while a higher one is held.
- R8: The mode term is true when `userMode` equals the user-enable bit, or when mode don't-care is set.
- R9: In duration mode the count advances on every second clock edge while the condition holds. The first edge after a clear does not count, so N edges give floor(N/2).
- R10: In event mode the count advances on the edge that follows each false-to-true change of the condition. A condition that is already true right after a clear counts as one event. A condition that stays true does not count again.
- R11: A control write with the clear bit set makes the count 0 on that edge, overriding any increment. A control write without the clear bit leaves the count unchanged.
- R12: The count wraps from 2^CNT_W-1 to 0 without any other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; duration mode counts at half this rate |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Loads the control word this cycle |
| cfgData | input | NCH+NLVL+14 | Control word (layout in R2) |
| chanBusy | input | NCH | Busy flag of each internal channel |
| ucodeState | input | 2 | Current microcode state code |
| probeIn | input | 1 | External probe line |
| cacheAct | input | 4 | Cache activities: fill, wait, writeback, sweep |
| lvlHeld | input | NLVL | Interrupt levels held or cycling, index 0 highest |
| userMode | input | 1 | 1 when running in user mode |
| countOut | output | CNT_W | Registered counter value |

## Verification
Each qualifier term is tested alone while every other term is forced true through its don't-care bit or the no-level enable. One pattern makes the term true and one makes it false, which shows that the term gates the AND by itself. The level term gets a case where a lower-priority level is held and enabled but a higher level is held and not enabled, which tells true priority selection apart from a plain OR. Each pattern runs alternately in duration and event mode. Held conditions, pulsed conditions and a train of pulses long enough to wrap the counter separate half-rate duration counting from edge counting.

// File: rtl/perf_pkg.sv
package perf_pkg;

  // Strobes sent from the control section to the counter datapath
  typedef struct packed {
    logic clr;
    logic inc;
  } perf_strobe_t;

  // Cache activity sources; the value is the bit index in cacheAct and in
  // the cache-enable field
  typedef enum logic [1:0] {
    CACHE_FILL  = 2'd0,
    CACHE_WAIT  = 2'd1,
    CACHE_EBWB  = 2'd2,
    CACHE_SWEEP = 2'd3
  } cache_src_e;

  localparam int CACHE_N = 4;

  // Microcode state code that qualifies the state term
  localparam logic [1:0] USTATE_QUAL = 2'b01;

endpackage

// File: rtl/perf_qual_cond.sv
module perf_qual_cond
  import perf_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NLVL  = 8,
  parameter int CFG_W = NCH + NLVL + 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CFG_W-1:0]   cfgQ,
  input  logic [NCH-1:0]     chanBusy,
  input  logic [1:0]         ucodeState,
  input  logic               probeIn,
  input  logic [CACHE_N-1:0] cacheAct,
  input  logic [NLVL-1:0]    lvlHeld,
  input  logic               userMode,
  output logic               cond
);

  // Field positions of the control word
  localparam int CHEN_LO = 0;
  localparam int CHDC    = NCH;
  localparam int STDC    = NCH + 1;
  localparam int PRLOW   = NCH + 2;
  localparam int PRDC    = NCH + 3;
  localparam int CAEN_LO = NCH + 4;
  localparam int CADC    = CAEN_LO + CACHE_N;
  localparam int LVEN_LO = CADC + 1;
  localparam int NOLV    = LVEN_LO + NLVL;
  localparam int USEN    = NOLV + 1;
  localparam int MODC    = NOLV + 2;
  localparam int EVT     = NOLV + 3;
  localparam int CLR     = NOLV + 4;

  logic termA, termB, termC, termD, termE, termF;
  logic [NCH-1:0]     chanHit;
  logic [CACHE_N-1:0] cacheHit;
  logic [NLVL:0]      noneAbove;
  logic [NLVL-1:0]    lvlSel;
  logic [NLVL-1:0]    lvlHit;
  logic               unusedCfg;

  assign unusedCfg = ^{cfgQ[EVT], cfgQ[CLR]};

  // Channel term: one AND per channel
  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign chanHit[i] = chanBusy[i] & cfgQ[CHEN_LO + i];
  end

  // Cache term: one AND per activity source
  for (genvar k = 0; k < CACHE_N; k++) begin : g_cache
    assign cacheHit[k] = cacheAct[k] & cfgQ[CAEN_LO + k];
  end

  // Level term: priority chain, index 0 is the highest level
  assign noneAbove[0] = 1'b1;
  for (genvar n = 0; n < NLVL; n++) begin : g_lvl
    assign lvlSel[n]       = lvlHeld[n] & noneAbove[n];
    assign noneAbove[n+1]  = noneAbove[n] & ~lvlHeld[n];
    assign lvlHit[n]       = lvlSel[n] & cfgQ[LVEN_LO + n];
  end

  always_comb begin
    termA = (|chanHit) | cfgQ[CHDC];
    termB = (ucodeState == USTATE_QUAL) | cfgQ[STDC];
    termC = (probeIn != cfgQ[PRLOW]) | cfgQ[PRDC];
    termD = (|cacheHit) | cfgQ[CADC];
    termE = (|lvlHit) | (noneAbove[NLVL] & cfgQ[NOLV]);
    termF = (userMode == cfgQ[USEN]) | cfgQ[MODC];
    cond  = termA & termB & termC & termD & termE & termF;
  end

  // R3 R4 R5 R6 R8: every don't-care set and no level held with no-level enabled
  // R7
  all_dc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[CHDC] && cfgQ[STDC] && cfgQ[PRDC] && cfgQ[CADC] && cfgQ[MODC] &&
     cfgQ[NOLV] && (lvlHeld == '0)) |-> cond);

  // R7
  lvl_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lvlHeld[0] && !cfgQ[LVEN_LO]) |-> !cond);

endmodule

// File: rtl/perf_ctrl.sv
module perf_ctrl
  import perf_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NLVL  = 8,
  parameter int CFG_W = NCH + NLVL + 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             cond,
  output logic [CFG_W-1:0] cfgQ,
  output perf_strobe_t     strobe
);

  localparam int EVT = CFG_W - 2;
  localparam int CLR = CFG_W - 1;

  logic phaseQ;
  logic prevCondQ;
  logic eventMode;

  assign eventMode = cfgQ[EVT];

  always_comb begin
    strobe.clr = cfgWrite & cfgData[CLR];
    if (eventMode) strobe.inc = cond & ~prevCondQ;
    else           strobe.inc = cond & phaseQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ      <= '0;
      phaseQ    <= 1'b0;
      prevCondQ <= 1'b0;
    end else begin
      if (cfgWrite) begin
        cfgQ      <= cfgData;
        cfgQ[CLR] <= 1'b0;
      end
      if (strobe.clr) begin
        phaseQ    <= 1'b0;
        prevCondQ <= 1'b0;
      end else begin
        phaseQ    <= ~phaseQ;
        prevCondQ <= cond;
      end
    end
  end

  // R9 R10: no increments on two consecutive cycles without a control write
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !cfgWrite) |=> !strobe.inc);

  // R10
  event_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventMode && cond && $past(cond) && !$past(cfgWrite)) |-> !strobe.inc);

endmodule

// File: rtl/perf_datapath.sv
module perf_datapath
  import perf_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  perf_strobe_t     strobe,
  output logic [CNT_W-1:0] countQ
);

  always_ff @(posedge clk) begin
    if (!rstN)           countQ <= '0;
    else if (strobe.clr) countQ <= '0;
    else if (strobe.inc) countQ <= countQ + 1'b1;
  end

  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (countQ == '0));

  // R12
  inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !strobe.clr) |=> (countQ == $past(countQ) + 1'b1));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.inc && !strobe.clr) |=> $stable(countQ));

endmodule

// File: rtl/perf_qual_counter.sv
module perf_qual_counter
  import perf_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NLVL  = 8,
  parameter int CNT_W = 32,
  parameter int CFG_W = NCH + NLVL + 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrite,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic [NCH-1:0]     chanBusy,
  input  logic [1:0]         ucodeState,
  input  logic               probeIn,
  input  logic [CACHE_N-1:0] cacheAct,
  input  logic [NLVL-1:0]    lvlHeld,
  input  logic               userMode,
  output logic [CNT_W-1:0]   countOut
);

  logic [CFG_W-1:0] cfgQ;
  logic             cond;
  perf_strobe_t     strobe;

  perf_qual_cond #(.NCH(NCH), .NLVL(NLVL), .CFG_W(CFG_W)) u_cond (
    .clk        (clk),
    .rstN       (rstN),
    .cfgQ       (cfgQ),
    .chanBusy   (chanBusy),
    .ucodeState (ucodeState),
    .probeIn    (probeIn),
    .cacheAct   (cacheAct),
    .lvlHeld    (lvlHeld),
    .userMode   (userMode),
    .cond       (cond)
  );

  perf_ctrl #(.NCH(NCH), .NLVL(NLVL), .CFG_W(CFG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrite (cfgWrite),
    .cfgData  (cfgData),
    .cond     (cond),
    .cfgQ     (cfgQ),
    .strobe   (strobe)
  );

  perf_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .countQ (countOut)
  );

endmodule

// File: tb/perf_qual_counter_test.sv
module perf_qual_counter_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int NVEC       = 19;

  // Control word bits (layout of R2)
  localparam logic [29:0] CHEN0     = 30'h0000001;
  localparam logic [29:0] CHEN5     = 30'h0000020;
  localparam logic [29:0] CHDC      = 30'h0000100;
  localparam logic [29:0] STDC      = 30'h0000200;
  localparam logic [29:0] PRLOW     = 30'h0000400;
  localparam logic [29:0] PRDC      = 30'h0000800;
  localparam logic [29:0] CEN_WAIT  = 30'h0002000;
  localparam logic [29:0] CEN_SWEEP = 30'h0008000;
  localparam logic [29:0] CADC      = 30'h0010000;
  localparam logic [29:0] LVEN1     = 30'h0040000;
  localparam logic [29:0] LVEN2     = 30'h0080000;
  localparam logic [29:0] NOLV      = 30'h2000000;
  localparam logic [29:0] USEN      = 30'h4000000;
  localparam logic [29:0] MODC      = 30'h8000000;
  localparam logic [29:0] EVT       = 30'h10000000;
  localparam logic [29:0] CLR       = 30'h20000000;
  localparam logic [29:0] DC        = CHDC | STDC | PRDC | CADC | NOLV | MODC;

  typedef struct packed {
    logic [29:0] cfg;
    logic [7:0]  busy;
    logic [1:0]  ust;
    logic        probe;
    logic [3:0]  cache;
    logic [7:0]  held;
    logic        user;
    logic        expCond;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{DC & ~CHDC | CHEN5,       8'h20, 2'b00, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b1, 4'd3}, // R3
    '{DC & ~CHDC | CHEN5,       8'h10, 2'b00, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b0, 4'd3}, // R3
    '{DC & ~STDC,               8'h00, 2'b01, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b1, 4'd4}, // R4
    '{DC & ~STDC,               8'h00, 2'b10, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b0, 4'd4}, // R4
    '{DC & ~STDC,               8'h00, 2'b11, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b0, 4'd4}, // R4
    '{DC & ~PRDC,               8'h00, 2'b00, 1'b1, 4'b0000, 8'h00, 1'b0, 1'b1, 4'd5}, // R5
    '{DC & ~PRDC | PRLOW,       8'h00, 2'b00, 1'b1, 4'b0000, 8'h00, 1'b0, 1'b0, 4'd5}, // R5
    '{DC & ~PRDC | PRLOW,       8'h00, 2'b00, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b1, 4'd5}, // R5
    '{DC & ~CADC | CEN_WAIT,    8'h00, 2'b00, 1'b0, 4'b0010, 8'h00, 1'b0, 1'b1, 4'd6}, // R6
    '{DC & ~CADC | CEN_SWEEP,   8'h00, 2'b00, 1'b0, 4'b0111, 8'h00, 1'b0, 1'b0, 4'd6}, // R6
    '{DC & ~NOLV | LVEN1,       8'h00, 2'b00, 1'b0, 4'b0000, 8'h06, 1'b0, 1'b1, 4'd7}, // R7
    '{DC & ~NOLV | LVEN2,       8'h00, 2'b00, 1'b0, 4'b0000, 8'h06, 1'b0, 1'b0, 4'd7}, // R7
    '{DC & ~NOLV,               8'h00, 2'b00, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b0, 4'd7}, // R7
    '{DC,                       8'h00, 2'b00, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b1, 4'd7}, // R7
    '{DC & ~MODC | USEN,        8'h00, 2'b00, 1'b0, 4'b0000, 8'h00, 1'b1, 1'b1, 4'd8}, // R8
    '{DC & ~MODC | USEN,        8'h00, 2'b00, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b0, 4'd8}, // R8
    '{DC & ~MODC,               8'h00, 2'b00, 1'b0, 4'b0000, 8'h00, 1'b0, 1'b1, 4'd8}, // R8
    '{DC & ~MODC,               8'h00, 2'b00, 1'b0, 4'b0000, 8'h00, 1'b1, 1'b0, 4'd8}, // R8
    '{30'h0,                    8'hFF, 2'b01, 1'b1, 4'b1111, 8'h01, 1'b0, 1'b0, 4'd3}  // R3
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              cfgWrite;
  logic [29:0]       cfgData;
  logic [7:0]        chanBusy;
  logic [1:0]        ucodeState;
  logic              probeIn;
  logic [3:0]        cacheAct;
  logic [7:0]        lvlHeld;
  logic              userMode;
  logic [CNT_W-1:0]  countOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_qual_counter #(.NCH(8), .NLVL(8), .CNT_W(CNT_W)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrite   (cfgWrite),
    .cfgData    (cfgData),
    .chanBusy   (chanBusy),
    .ucodeState (ucodeState),
    .probeIn    (probeIn),
    .cacheAct   (cacheAct),
    .lvlHeld    (lvlHeld),
    .userMode   (userMode),
    .countOut   (countOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge
  task automatic writeCfg(input logic [29:0] d);
    cfgWrite = 1'b1;
    cfgData  = d;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWrite = 1'b0; cfgData = '0;
    chanBusy = '0; ucodeState = '0; probeIn = 1'b0; cacheAct = '0;
    lvlHeld = '0; userMode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 count in reset", int'(countOut), 0);
    rstN = 1'b1;

    // R1: all status active, data present but no write: stays 0
    chanBusy = 8'hFF; ucodeState = 2'b01; probeIn = 1'b1; cacheAct = 4'hF;
    cfgData = DC | EVT;
    repeat (6) @(negedge clk);
    check("R1 default config counts nothing", int'(countOut), 0);

    // Table walk: each qualifier pattern, alternating duration/event
    for (int i = 0; i < NVEC; i++) begin
      automatic vec_t v = VECS[i];
      automatic bit evt = (i % 2) == 1;
      automatic int exp = v.expCond ? (evt ? 1 : 5) : 0;
      chanBusy = v.busy; ucodeState = v.ust; probeIn = v.probe;
      cacheAct = v.cache; lvlHeld = v.held; userMode = v.user;
      writeCfg(v.cfg | CLR | (evt ? EVT : 30'h0));
      repeat (10) @(negedge clk);
      check($sformatf("R%0d vector %0d %s", v.req, i, evt ? "event R10" : "duration R9"),
            int'(countOut), exp);
    end

    // R9: half-rate duration counting, first edge after clear skipped
    chanBusy = '0; ucodeState = '0; probeIn = 1'b0; cacheAct = '0;
    lvlHeld = '0; userMode = 1'b0;
    writeCfg(DC | CLR);
    check("R9 zero right after clear", int'(countOut), 0);
    @(negedge clk);
    check("R9 first edge not counted", int'(countOut), 0);
    @(negedge clk);
    check("R9 second edge counted", int'(countOut), 1);
    repeat (5) @(negedge clk);
    check("R9 seven edges give three", int'(countOut), 3);

    // R11: clear overrides, plain write keeps count
    writeCfg(DC | CLR);
    check("R11 clear zeroes count", int'(countOut), 0);
    writeCfg(DC | EVT | CLR);
    repeat (3) @(negedge clk);
    check("R10 held condition counts once", int'(countOut), 1);
    writeCfg(DC | EVT);
    check("R11 write without clear keeps count", int'(countOut), 1);
    repeat (3) @(negedge clk);
    check("R11 count still kept", int'(countOut), 1);
    writeCfg(DC | EVT | CLR);
    check("R11 clear with condition true", int'(countOut), 0);
    @(negedge clk);
    check("R10 already-true after clear counts one", int'(countOut), 1);

    // R10 / R12: pulse train on channel 0 in event mode
    chanBusy = 8'h00;
    writeCfg(DC & ~CHDC | CHEN0 | EVT | CLR);
    for (int p = 0; p < 3; p++) begin
      chanBusy = 8'h01; @(negedge clk);
      chanBusy = 8'h00; @(negedge clk);
    end
    check("R10 three pulses three events", int'(countOut), 3);
    for (int p = 0; p < 256; p++) begin
      chanBusy = 8'h01; @(negedge clk);
      chanBusy = 8'h00; @(negedge clk);
    end
    check("R12 wrap after 256 more events", int'(countOut), 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule